// File: doc/BRIEF.md
# Daisy-Chain Command Frame Encoder

This block turns one register access for a chain of stacked battery-monitor devices into a 32-bit serial command and sends it as an SPI master. The caller supplies a 5-bit target device address, a 6-bit register address, an 8-bit data byte and a broadcast flag. The block packs these fields into the upper 21 bits of the word. It appends an 8-bit checksum, which is the remainder of those 21 bits divided by x^8+x^5+x^3+x^2+x+1, and then a fixed 3-bit tail. The word is sent most significant bit first, with SPI clock polarity 0 and phase 1.

Reading data back from the chain needs a valid write word to be clocked out while the responses are shifted in. For this, the caller can request a fixed read word instead of building a command. The SPI clock is produced by a divider on the system clock; the default divider gives about 700 kHz from 200 MHz, which keeps the link under its 1 MHz limit. A valid/ready handshake launches a frame. The block reports `busy` while chip select is low and gives a one-cycle `done` pulse when chip select is released.

Top module: `chain_cmd_spi_tx`

## Requirements
- R1: For a normal command, the word has the device address at bits 31:27, the register address at 26:21, the data at 20:13 and the broadcast flag at bit 12. Bit 11 is 0, and bits 2:0 are 3'b010.
- R2: Bits 10:3 hold the remainder of word bits 31:11, taken as a 21-bit polynomial, modulo x^8+x^5+x^3+x^2+x+1 (low byte 8'h2F). No zero bits are appended before the division. For example, device 5'h1F with all other fields 0 gives 32'hF800030A.
- R3: When `in_read_only` is 1 at acceptance, the word sent is 32'hF800030A, whatever the other field inputs are.
- R4: SPI mode 1 applies. `spi_sclk` is low whenever `spi_cs_n` is high. During a frame, `spi_mosi` changes only in the cycle where `spi_sclk` rises, so a receiver sampling on the falling edge sees bit 31 first and bit 0 last.
- R5: Each frame has exactly 32 `spi_sclk` pulses while `spi_cs_n` is low.
- R6: Each `spi_sclk` high phase and low phase lasts HALF_DIV system clocks. `spi_cs_n` falls HALF_DIV clocks before the first rising edge and rises HALF_DIV clocks after the last falling edge.
- R7: `in_ready` is 1 only while idle. A request with `in_valid` and `in_ready` both high pulls `spi_cs_n` low in the next cycle, and `busy` equals the inverse of `spi_cs_n`.
- R8: `done` is a one-cycle pulse in the cycle where `spi_cs_n` returns high, and it occurs exactly once per frame.
- R9: Changes to the field inputs or to `in_valid` while a frame is in progress do not alter the word being sent. A request that is withdrawn before the frame ends starts no further frame.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `busy`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request to send a frame |
| in_ready | output | 1 | Block is idle and accepts a request |
| in_read_only | input | 1 | Send the fixed read word instead of a command |
| in_dev_addr | input | 5 | Target device address (0 is the first device) |
| in_reg_addr | input | 6 | Target register address |
| in_data | input | 8 | Data byte to write |
| in_bcast | input | 1 | Broadcast to every device in the chain |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out, MSB first |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with HALF_DIV=3 rather than the default of 143. An odd divider of 3 shows clearly whether each clock phase really lasts HALF_DIV cycles, and not one more or one less. A full frame takes only 195 system clocks, so every vector in the table, the broadcast and all-ones field patterns, the read-word override, and a request held across a busy frame all fit in a short run. The frame addressed to device 5'h1F has to reproduce the known read word exactly, which checks the checksum against a fixed value as well as against the bench's bit-serial division.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

    localparam int DEV_W  = 5;
    localparam int REG_W  = 6;
    localparam int DAT_W  = 8;
    localparam int CRC_W  = 8;
    localparam int TAIL_W = 3;
    localparam int WORD_W = 32;
    // header = fields plus one zero pad bit, which sits at word bit 11
    localparam int HDR_W  = DEV_W + REG_W + DAT_W + 1 + 1;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    localparam logic [CRC_W-1:0]  POLY_LO   = 8'h2F;
    localparam logic [TAIL_W-1:0] TAIL_BITS = 3'b010;
    localparam logic [WORD_W-1:0] READ_WORD = 32'hF800030A;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [REG_W-1:0] regsel;
        logic [DAT_W-1:0] data;
        logic             bcast;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TRAIL
    } phase_e;

    // remainder of x^n modulo the generator polynomial
    function automatic logic [CRC_W-1:0] xpow_rem(input int n);
        logic [CRC_W-1:0] r;
        r = 8'h01;
        for (int k = 0; k < n; k++) begin
            r = {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? POLY_LO : 8'h00);
        end
        return r;
    endfunction

endpackage

// File: rtl/chain_crc8_rem.sv
module chain_crc8_rem
    import chain_cmd_pkg::*;
#(
    parameter int IN_W = HDR_W
) (
    input  logic [IN_W-1:0]  msg,
    output logic [CRC_W-1:0] rem
);

    logic [CRC_W-1:0] term [IN_W];

    // each message bit contributes a constant: x^i mod P
    for (genvar g = 0; g < IN_W; g++) begin : g_bit
        localparam logic [CRC_W-1:0] KW = xpow_rem(g);
        assign term[g] = msg[g] ? KW : '0;
    end

    always_comb begin
        rem = '0;
        for (int i = 0; i < IN_W; i++) begin
            rem = rem ^ term[i];
        end
    end

endmodule

// File: rtl/chain_frame_pack.sv
module chain_frame_pack
    import chain_cmd_pkg::*;
(
    input  cmd_t              cmd,
    input  logic              read_only,
    output logic [WORD_W-1:0] word
);

    logic [HDR_W-1:0] hdr;
    logic [CRC_W-1:0] crc;

    assign hdr = {cmd.dev, cmd.regsel, cmd.data, cmd.bcast, 1'b0};

    chain_crc8_rem #(.IN_W(HDR_W)) u_crc (
        .msg (hdr),
        .rem (crc)
    );

    assign word = read_only ? READ_WORD : {hdr, crc, TAIL_BITS};

endmodule

// File: rtl/chain_sclk_tick.sv
module chain_sclk_tick #(
    parameter int HALF_DIV = 143
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/chain_cmd_spi_tx.sv
module chain_cmd_spi_tx
    import chain_cmd_pkg::*;
#(
    parameter int HALF_DIV = 143
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_read_only,
    input  logic [DEV_W-1:0] in_dev_addr,
    input  logic [REG_W-1:0] in_reg_addr,
    input  logic [DAT_W-1:0] in_data,
    input  logic             in_bcast,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        phase_e            ph;
        logic [WORD_W-1:0] sreg;
        logic [CNT_W-1:0]  nfall;
        logic              sclk;
        logic              cs_n;
        logic              busy;
        logic              done;
    } regs_t;

    localparam regs_t RESET_REGS = '{
        ph:    PH_IDLE,
        sreg:  '0,
        nfall: '0,
        sclk:  1'b0,
        cs_n:  1'b1,
        busy:  1'b0,
        done:  1'b0
    };

    regs_t             d, q;
    cmd_t              cmd;
    logic [WORD_W-1:0] word;
    logic              tick;

    assign cmd = '{dev: in_dev_addr, regsel: in_reg_addr, data: in_data, bcast: in_bcast};

    chain_frame_pack u_pack (
        .cmd       (cmd),
        .read_only (in_read_only),
        .word      (word)
    );

    chain_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.ph != PH_IDLE),
        .tick  (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    d.ph    = PH_LEAD;
                    d.sreg  = word;
                    d.nfall = '0;
                    d.cs_n  = 1'b0;
                    d.busy  = 1'b1;
                end
            end
            PH_LEAD: begin
                if (tick) begin
                    d.sclk = 1'b1;
                    d.ph   = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    d.sclk  = 1'b0;
                    d.nfall = q.nfall + 1'b1;
                    d.ph    = (q.nfall == CNT_W'(WORD_W - 1)) ? PH_TRAIL : PH_LOW;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    d.sclk = 1'b1;
                    d.sreg = {q.sreg[WORD_W-2:0], 1'b0};
                    d.ph   = PH_HIGH;
                end
            end
            PH_TRAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.sreg = '0;
                    d.ph   = PH_IDLE;
                end
            end
            default: d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_REGS;
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.ph == PH_IDLE);
    assign spi_sclk = q.sclk;
    assign spi_cs_n = q.cs_n;
    assign spi_mosi = q.sreg[WORD_W-1];
    assign busy     = q.busy;
    assign done     = q.done;

endmodule

// File: rtl/chain_cmd_spi_tx_chk.sv
module chain_cmd_spi_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic busy,
    input logic done
);

    logic       sclk_prev_q;
    logic [6:0] rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            rises_q     <= '0;
        end else begin
            sclk_prev_q <= spi_sclk;
            if (spi_cs_n) begin
                rises_q <= '0;
            end else if (spi_sclk && !sclk_prev_q) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk) else $error("sclk high while deselected"); // R4

    AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$rose(spi_sclk)) |-> $stable(spi_mosi))
        else $error("mosi moved off a rising edge"); // R4

    AST_PULSES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rises_q == 7'd32)) else $error("wrong pulse count"); // R5

    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!spi_cs_n && busy)) else $error("accept failed"); // R7

    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !spi_cs_n) else $error("busy mismatch"); // R7

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(spi_cs_n)) else $error("done misplaced"); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R8

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready) else $error("ready while busy"); // R9

endmodule

bind chain_cmd_spi_tx chain_cmd_spi_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .busy     (busy),
    .done     (done)
);

// File: tb/chain_cmd_spi_tx_bench.sv
`timescale 1ns/1ps
module chain_cmd_spi_tx_bench;

    localparam int HALF  = 3;
    localparam int NVEC  = 8;
    localparam logic [31:0] RD_WORD = 32'hF800030A;

    // {read_only, dev[4:0], reg[5:0], data[7:0], bcast}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 5'h00, 6'h0D, 8'hA5, 1'b1},
        {1'b0, 5'h1F, 6'h00, 8'h00, 1'b0},
        {1'b0, 5'h15, 6'h2A, 8'h3C, 1'b0},
        {1'b0, 5'h0A, 6'h15, 8'hC3, 1'b0},
        {1'b0, 5'h1F, 6'h3F, 8'hFF, 1'b1},
        {1'b0, 5'h00, 6'h00, 8'h00, 1'b0},
        {1'b1, 5'h05, 6'h11, 8'h77, 1'b1},
        {1'b0, 5'h01, 6'h14, 8'h80, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_read_only = 1'b0;
    logic [4:0] in_dev_addr = '0;
    logic [5:0] in_reg_addr = '0;
    logic [7:0] in_data = '0;
    logic       in_bcast = 1'b0;
    logic       spi_sclk, spi_cs_n, spi_mosi, busy, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    chain_cmd_spi_tx #(.HALF_DIV(HALF)) u_chain_cmd_spi_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_read_only (in_read_only),
        .in_dev_addr  (in_dev_addr),
        .in_reg_addr  (in_reg_addr),
        .in_data      (in_data),
        .in_bcast     (in_bcast),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .busy         (busy),
        .done         (done)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] ref_crc(input logic [20:0] v);
        logic [7:0] r = '0;
        logic       fb;
        for (int i = 20; i >= 0; i--) begin
            fb = r[7];
            r  = {r[6:0], v[i]};
            if (fb) r = r ^ 8'h2F;
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [20:0] v);
        logic [20:0] hdr;
        if (v[20]) return RD_WORD;
        hdr = {v[19:15], v[14:9], v[8:1], v[0], 1'b0};
        return {hdr, ref_crc(hdr), 3'b010};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- SPI monitor (samples on falling system clock) ----------------
    logic [31:0] rx_word = '0;
    int          nbits = 0, tbad = 0, ndone = 0, frames = 0;
    int          lowrun = 0, hirun = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n) begin
                rx_word = '0; nbits = 0; tbad = 0; ndone = 0;
                lowrun = 0; hirun = 0;
            end
            if (!spi_cs_n) begin
                if (spi_sclk) begin
                    if (!prev_sclk) begin
                        if (lowrun != HALF) tbad++;
                        lowrun = 0;
                    end
                    hirun++;
                end else begin
                    if (prev_sclk) begin
                        rx_word = {rx_word[30:0], spi_mosi};
                        nbits++;
                        if (hirun != HALF) tbad++;
                        hirun = 0;
                    end
                    lowrun++;
                end
            end else if (!prev_cs) begin
                if (lowrun != HALF) tbad++;
                if (spi_sclk) tbad++;
                frames++;
            end
            if (done) begin
                ndone++;
                if (!(spi_cs_n && !prev_cs)) tbad++;
            end
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    task automatic drive(input logic [20:0] v);
        {in_read_only, in_dev_addr, in_reg_addr, in_data, in_bcast} = v;
    endtask

    task automatic wait_frame(input int start);
        while (frames == start) @(posedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_checks(input logic [31:0] exp, input string wreq);
        chk(rx_word == exp, wreq, rx_word, exp);
        chk(nbits == 32, "R5 bit count", 32'(nbits), 32'd32);
        chk(tbad == 0, "R6 phase timing", 32'(tbad), 32'd0);
        chk(ndone == 1, "R8 done pulses", 32'(ndone), 32'd1);
    endtask

    task automatic send(input logic [20:0] v);
        int start;
        start = frames;
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        wait_frame(start);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R10 pins in reset",
            {29'd0, spi_cs_n, spi_sclk, spi_mosi}, 32'h4);
        chk(busy == 1'b0 && done == 1'b0 && in_ready == 1'b1, "R10 status in reset",
            {29'd0, busy, done, in_ready}, 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && in_ready, "R10 idle after reset",
            {29'd0, spi_cs_n, spi_sclk, in_ready}, 32'h5);

        // table of vectors: R1 fields, R2 checksum, R3 read word
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i]);
            frame_checks(ref_word(VEC[i]), VEC[i][20] ? "R3 read word" : "R1 R2 word");
        end

        // R2: device 1F, other fields zero reproduces the fixed read word
        send({1'b0, 5'h1F, 6'h00, 8'h00, 1'b0});
        chk(rx_word == RD_WORD, "R2 known checksum", rx_word, RD_WORD);

        // R1: all-zero fields leave only the tail bits
        send('0);
        chk(rx_word == 32'h0000_0002, "R1 tail only", rx_word, 32'h0000_0002);

        // R4: idle between frames keeps sclk low
        chk(!spi_sclk && spi_cs_n, "R4 idle sclk", {30'd0, spi_sclk, spi_cs_n}, 32'h1);

        // R7 / R9: request held and fields changed while busy
        begin
            int start;
            logic [20:0] va, vb;
            va = {1'b0, 5'h03, 6'h1C, 8'h5A, 1'b0};
            vb = {1'b0, 5'h1C, 6'h23, 8'hA5, 1'b1};
            start = frames;
            @(negedge clk);
            drive(va);
            in_valid = 1'b1;
            @(negedge clk);
            drive(vb);
            repeat (20) @(negedge clk);
            chk(!in_ready && busy && !spi_cs_n, "R7 busy mid-frame",
                {29'd0, in_ready, busy, spi_cs_n}, 32'h2);
            repeat (30) @(negedge clk);
            in_valid = 1'b0;
            wait_frame(start);
            frame_checks(ref_word(va), "R9 word unchanged");
            repeat (40) @(negedge clk);
            chk(frames == start + 1 && spi_cs_n, "R9 no extra frame",
                32'(frames - start), 32'd1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule